// File: doc/BRIEF.md
# Monochrome Pattern Colour Expander

This block stores a 64-bit one-bit-per-pixel pattern along with two colour values, and turns a pixel coordinate into one of those two colours. Software loads the registers through a simple write port: a shape code, colour 0, colour 1, and the pattern as an upper and a lower 32-bit word. A drawing engine then presents (x, y) coordinates on the lookup port. One clock later the block returns the colour that the matching pattern bit selects, together with a valid flag.

The same 64 pattern bits can be read in three layouts, chosen at run time: an 8x8 tile that repeats across the screen, a 64-pixel horizontal strip, or a 64-pixel vertical strip. The coordinate wraps onto the pattern in each layout. A write of a shape code the block does not support is refused and flagged, so a bad code can never reach the index logic.

Top module: `pce_top`

## Requirements
- R1: After reset, colour 0, colour 1, both pattern words and the shape all read as zero. Both wr_err and lk_valid are low, and a lookup returns colour value 0.
- R2: A write with wr_en high is decoded by wr_addr. 0x308 is the shape, 0x310 is colour 0, 0x314 is colour 1, 0x318 is pattern bits 63..32 and 0x31C is pattern bits 31..0. Pattern bit index 0 is bit 0 of the 0x31C word.
- R3: A pattern bit of 0 returns colour 0 and a pattern bit of 1 returns colour 1.
- R4: With shape code 0 (8x8 tile) the bit index is (y mod 8)*8 + (x mod 8).
- R5: With shape code 1 (64-wide strip) the bit index is x mod 64.
- R6: With shape code 2 (64-high strip) the bit index is y mod 64.
- R7: A shape write whose full 32-bit data is greater than 2 leaves the shape unchanged. It raises wr_err for exactly one cycle, in the cycle after the write.
- R8: A shape write of 0, 1 or 2 is accepted, and no legal write raises wr_err.
- R9: lk_valid is high in exactly the cycle after a cycle with lk_req high. lk_color is valid in that same cycle.
- R10: Writes to any other offset, 0x304 included, change no register and raise no error.
- R11: A lookup in the same cycle as a register write uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte offset |
| wr_data | input | 32 | Register write data |
| wr_err | output | 1 | One-cycle pulse when a shape write is refused |
| lk_req | input | 1 | Lookup request |
| lk_x | input | 16 | Pixel x coordinate |
| lk_y | input | 16 | Pixel y coordinate |
| lk_valid | output | 1 | Lookup result valid, one cycle after request |
| lk_color | output | 32 | Selected pattern colour |

## Verification
The case that is hardest to reach from the ports is a register write and a lookup that land on the same clock edge. The result must show the old colour, not the one being written. The bench drives both strobes on the same falling edge, with a coordinate whose pattern bit picks the colour being overwritten. A second lookup then confirms that the new value took effect. Refused shape codes are sent only after a legal non-zero shape is in place, so that "unchanged" can be told apart from the reset value. Every layout is tested at coordinates past 63 and past 7 so that the wrap is exercised.

// File: rtl/pce_pkg.sv
package pce_pkg;

   typedef enum logic [1:0] {
      SHP_TILE = 2'd0,
      SHP_ROW  = 2'd1,
      SHP_COL  = 2'd2
   } shape_e;

   localparam int unsigned SHAPE_MAX = 2;

   localparam logic [11:0] OFS_SHAPE  = 12'h308;
   localparam logic [11:0] OFS_COLOR0 = 12'h310;
   localparam logic [11:0] OFS_COLOR1 = 12'h314;
   localparam logic [11:0] OFS_PAT_HI = 12'h318;
   localparam logic [11:0] OFS_PAT_LO = 12'h31C;

endpackage

// File: rtl/pce_regfile.sv
module pce_regfile
   import pce_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned COLOR_W  = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned PAT_BITS = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   output shape_e              shape_o,
   output logic [COLOR_W-1:0]  color0_o,
   output logic [COLOR_W-1:0]  color1_o,
   output logic [PAT_BITS-1:0] pattern_o,
   output logic                wr_err_o
);
   localparam int unsigned NWORDS = PAT_BITS / DATA_W;
   localparam logic [ADDR_W-1:0] A_SHAPE = ADDR_W'(OFS_SHAPE);
   localparam logic [ADDR_W-1:0] A_C0    = ADDR_W'(OFS_COLOR0);
   localparam logic [ADDR_W-1:0] A_C1    = ADDR_W'(OFS_COLOR1);
   localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(OFS_PAT_HI);
   localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(OFS_PAT_LO);

   generate
      if (NWORDS != 2 || NWORDS * DATA_W != PAT_BITS) begin : g_bad_words
         $error("pce_regfile: pattern must split into two data words");
      end
      if (COLOR_W > DATA_W) begin : g_bad_color
         $error("pce_regfile: colour wider than write data");
      end
      if (ADDR_W < 10) begin : g_bad_addr
         $error("pce_regfile: address too narrow for register offsets");
      end
   endgenerate

   logic   hit_shape, hit_c0, hit_c1, shape_bad;
   shape_e shape_q;
   logic [COLOR_W-1:0] c0_q, c1_q;
   logic   err_q;

   always_comb begin
      hit_shape = wr_en && (wr_addr == A_SHAPE);
      hit_c0    = wr_en && (wr_addr == A_C0);
      hit_c1    = wr_en && (wr_addr == A_C1);
      shape_bad = wr_data > DATA_W'(SHAPE_MAX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shape_q <= SHP_TILE;
         err_q   <= 1'b0;
      end else begin
         err_q <= hit_shape && shape_bad;
         if (hit_shape && !shape_bad)
            shape_q <= shape_e'(wr_data[1:0]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c0_q <= '0;
         c1_q <= '0;
      end else begin
         if (hit_c0) c0_q <= wr_data[COLOR_W-1:0];
         if (hit_c1) c1_q <= wr_data[COLOR_W-1:0];
      end
   end

   genvar w;
   generate
      for (w = 0; w < NWORDS; w++) begin : g_word
         localparam logic [ADDR_W-1:0] WA = (w == NWORDS - 1) ? A_HI : A_LO;
         logic [DATA_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               word_q <= '0;
            else if (wr_en && wr_addr == WA)
               word_q <= wr_data;
         end
         assign pattern_o[w*DATA_W +: DATA_W] = word_q;
      end
   endgenerate

   assign shape_o  = shape_q;
   assign color0_o = c0_q;
   assign color1_o = c1_q;
   assign wr_err_o = err_q;

   // R7: the stored shape never holds an illegal code
   a_r7_shape_legal: assert property (@(posedge clk) disable iff (!rst_n)
      int'(shape_q) <= int'(SHAPE_MAX));

   // R7: an error pulse only follows a shape write, and the shape did not move
   a_r7_err_source: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> ($past(wr_en) && $past(wr_addr) == A_SHAPE && $stable(shape_q)));

   // R10: a write to an unmapped offset changes no colour
   a_r10_ignore_other: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != A_C0 && wr_addr != A_C1) |=> ($stable(c0_q) && $stable(c1_q)));

endmodule

// File: rtl/pce_index.sv
module pce_index
   import pce_pkg::*;
#(
   parameter int unsigned COORD_W  = 16,
   parameter int unsigned PAT_BITS = 64
) (
   input  shape_e                        shape,
   input  logic [COORD_W-1:0]            x,
   input  logic [COORD_W-1:0]            y,
   output logic [$clog2(PAT_BITS)-1:0]   idx
);
   localparam int unsigned IDX_W  = $clog2(PAT_BITS);
   localparam int unsigned SIDE_W = IDX_W / 2;
   localparam int unsigned SIDE   = 1 << SIDE_W;

   generate
      if ((1 << IDX_W) != PAT_BITS || (IDX_W % 2) != 0) begin : g_bad_bits
         $error("pce_index: pattern size must be a square power of two");
      end
      if (COORD_W < IDX_W) begin : g_bad_coord
         $error("pce_index: coordinate narrower than pattern index");
      end
   endgenerate

   logic [IDX_W-1:0]  x_line, y_line;
   logic [SIDE_W-1:0] x_tile, y_tile;

   always_comb begin
      x_line = IDX_W'(x % COORD_W'(PAT_BITS));
      y_line = IDX_W'(y % COORD_W'(PAT_BITS));
      x_tile = SIDE_W'(x % COORD_W'(SIDE));
      y_tile = SIDE_W'(y % COORD_W'(SIDE));
      unique case (shape)
         SHP_ROW:  idx = x_line;
         SHP_COL:  idx = y_line;
         default:  idx = {y_tile, x_tile};
      endcase
   end

endmodule

// File: rtl/pce_colsel.sv
module pce_colsel #(
   parameter int unsigned COLOR_W  = 32,
   parameter int unsigned PAT_BITS = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req,
   input  logic [$clog2(PAT_BITS)-1:0] idx,
   input  logic [PAT_BITS-1:0]         pattern,
   input  logic [COLOR_W-1:0]          color0,
   input  logic [COLOR_W-1:0]          color1,
   output logic                        valid_o,
   output logic [COLOR_W-1:0]          color_o
);
   logic               valid_q;
   logic [COLOR_W-1:0] color_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         color_q <= '0;
      end else begin
         valid_q <= req;
         if (req)
            color_q <= pattern[idx] ? color1 : color0;
      end
   end

   assign valid_o = valid_q;
   assign color_o = color_q;

   // R9: valid is the request delayed by exactly one clock
   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q == $past(req));

   // R3: a returned colour is always one of the two colour registers
   a_r3_two_colours: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (color_q == $past(color0) || color_q == $past(color1)));

endmodule

// File: rtl/pce_top.sv
module pce_top
   import pce_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned COLOR_W  = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned COORD_W  = 16,
   parameter int unsigned PAT_BITS = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               wr_err,
   input  logic               lk_req,
   input  logic [COORD_W-1:0] lk_x,
   input  logic [COORD_W-1:0] lk_y,
   output logic               lk_valid,
   output logic [COLOR_W-1:0] lk_color
);
   localparam int unsigned IDX_W = $clog2(PAT_BITS);

   shape_e              shape;
   logic [COLOR_W-1:0]  color0, color1;
   logic [PAT_BITS-1:0] pattern;
   logic [IDX_W-1:0]    idx;

   pce_regfile #(
      .DATA_W(DATA_W), .COLOR_W(COLOR_W), .ADDR_W(ADDR_W), .PAT_BITS(PAT_BITS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .shape_o(shape), .color0_o(color0), .color1_o(color1),
      .pattern_o(pattern), .wr_err_o(wr_err)
   );

   pce_index #(
      .COORD_W(COORD_W), .PAT_BITS(PAT_BITS)
   ) u_index (
      .shape(shape), .x(lk_x), .y(lk_y), .idx(idx)
   );

   pce_colsel #(
      .COLOR_W(COLOR_W), .PAT_BITS(PAT_BITS)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .req(lk_req), .idx(idx), .pattern(pattern),
      .color0(color0), .color1(color1), .valid_o(lk_valid), .color_o(lk_color)
   );

   // R7: an error pulse never lasts two cycles without a second refused write
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_err && !(wr_en && wr_addr == ADDR_W'(OFS_SHAPE))) |=> !wr_err);

endmodule

// File: tb/tb_pce_top.sv
module tb_pce_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [11:0] wr_addr;
   logic [31:0] wr_data;
   logic        wr_err;
   logic        lk_req;
   logic [15:0] lk_x, lk_y;
   logic        lk_valid;
   logic [31:0] lk_color;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // bench-side register model
   int unsigned m_shape;
   logic [31:0] m_c0, m_c1;
   logic [63:0] m_pat;

   always #5 clk = ~clk;

   pce_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_err(wr_err), .lk_req(lk_req), .lk_x(lk_x), .lk_y(lk_y),
      .lk_valid(lk_valid), .lk_color(lk_color)
   );

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [31:0] expect_col(input int unsigned x, input int unsigned y);
      int unsigned i;
      if (m_shape == 1)      i = x % 64;
      else if (m_shape == 2) i = y % 64;
      else                   i = (y % 8) * 8 + (x % 8);
      return m_pat[i] ? m_c1 : m_c0;
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bit bad_shape;
      bad_shape = (a == 12'h308) && (d > 2);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      chk(wr_err == bad_shape, bad_shape ? "R7 err pulse" : "R8 no err", 64'(wr_err), 64'(bad_shape));
      case (a)
         12'h308: if (!bad_shape) m_shape = d;
         12'h310: m_c0 = d;
         12'h314: m_c1 = d;
         12'h318: m_pat[63:32] = d;
         12'h31C: m_pat[31:0] = d;
         default: ;
      endcase
      if (bad_shape) begin
         @(negedge clk);
         chk(wr_err == 1'b0, "R7 single pulse", 64'(wr_err), 64'd0);
      end
   endtask

   task automatic look(input int unsigned x, input int unsigned y, input string rq);
      logic [31:0] e;
      e = expect_col(x, y);
      @(negedge clk);
      lk_req = 1'b1; lk_x = 16'(x); lk_y = 16'(y);
      @(negedge clk);
      lk_req = 1'b0;
      chk(lk_valid == 1'b1, "R9 valid", 64'(lk_valid), 64'd1);
      chk(lk_color == e, rq, 64'(lk_color), 64'(e));
   endtask

   task automatic t_reset;
      chk(lk_valid == 1'b0, "R1 valid low", 64'(lk_valid), 64'd0);
      chk(wr_err == 1'b0, "R1 err low", 64'(wr_err), 64'd0);
      look(3, 5, "R1 reset colour");
      look(200, 77, "R1 reset colour");
      @(negedge clk);
      chk(lk_valid == 1'b0, "R9 idle", 64'(lk_valid), 64'd0);
   endtask

   task automatic t_tile;
      wr(12'h310, 32'hA5A5_0001);
      wr(12'h314, 32'h5A5A_0002);
      wr(12'h31C, 32'h0000_0001);
      wr(12'h318, 32'h8000_0000);
      look(0, 0, "R2 R3 bit0 colour1");
      look(1, 0, "R3 bit1 colour0");
      look(7, 7, "R2 R4 bit63");
      look(8, 8, "R4 tile wrap");
      look(15, 23, "R4 tile wrap");
      wr(12'h31C, 32'hCAFE_8001);
      wr(12'h318, 32'hF0F0_1234);
      for (int k = 0; k < 10; k++) look(k * 5 + 3, k * 3 + 1, "R4 mixed");
   endtask

   task automatic t_row;
      wr(12'h308, 32'd1);
      look(63, 7, "R5 x63");
      look(64, 0, "R5 wrap");
      for (int k = 0; k < 8; k++) look(k * 9 + 2, 100 - k, "R5 strip");
   endtask

   task automatic t_col;
      wr(12'h308, 32'd2);
      look(5, 63, "R6 y63");
      look(9, 128, "R6 wrap");
      for (int k = 0; k < 8; k++) look(300 - k, k * 11 + 4, "R6 strip");
   endtask

   task automatic t_bad_shape;
      wr(12'h308, 32'd3);
      look(1, 37, "R7 shape kept");
      wr(12'h308, 32'h0000_0100);
      look(40, 62, "R7 shape kept");
      wr(12'h308, 32'd0);
      look(3, 6, "R8 shape 0 accepted");
   endtask

   task automatic t_other;
      wr(12'h304, 32'hFFFF_FFFF);
      wr(12'h30C, 32'h1234_5678);
      wr(12'h320, 32'h0);
      wr(12'h311, 32'h0);
      look(0, 0, "R10 ignored");
      look(5, 3, "R10 ignored");
      look(7, 7, "R10 ignored");
   endtask

   task automatic t_same_cycle;
      logic [31:0] old;
      old = m_c1;
      // (0,0) in tile mode: bit 0 of low word is 1, picks colour 1
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 12'h314; wr_data = 32'h0BAD_F00D;
      lk_req = 1'b1; lk_x = 16'd0; lk_y = 16'd0;
      @(negedge clk);
      wr_en = 1'b0; lk_req = 1'b0;
      chk(lk_color == old, "R11 old value", 64'(lk_color), 64'(old));
      m_c1 = 32'h0BAD_F00D;
      look(0, 0, "R11 new value");
   endtask

   initial begin
      wr_en = 0; wr_addr = '0; wr_data = '0; lk_req = 0; lk_x = '0; lk_y = '0;
      m_shape = 0; m_c0 = '0; m_c1 = '0; m_pat = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tile();
      t_row();
      t_col();
      t_bad_shape();
      t_other();
      t_same_cycle();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule